// File: doc/BRIEF.md
# Security-Aware Register Alias Decoder

This block sits in front of a banked system-register file and decodes a window of the private peripheral space. The window holds a 4 KB main register page at 0xE000E000 and a 4 KB alias page at 0xE002E000, which is 0x20000 higher. For every request the block works out an effective security attribute. It forwards the access to the register file with that attribute, or it answers the access itself with read-as-zero/write-ignored, or it returns a bus error.

Main-page accesses keep the security attribute they arrive with. The alias page lets secure software reach the non-secure copies of banked registers: a secure access there is forwarded with its attribute forced to non-secure. A non-secure access to the alias page gets a response that depends on privilege. A configuration strap states whether the security extension exists. When the strap is low, the alias page is never forwarded.

The register file here is a stub with two banks of a few words each. It exists so that the bank each access lands in can be observed. Each request takes one cycle. The response follows one cycle later.

Top module: `sra_alias_decoder`

## Requirements
- R1: An access with address in 0xE000E000..0xE000EFFF is forwarded to the register file with its own security attribute and completes without error.
- R2: With `sec_ext_en` high, a secure access to 0xE002E000..0xE002EFFF is forwarded with the attribute forced to non-secure, so it reaches bank 0 (the non-secure bank), without error.
- R3: A non-secure privileged access to the alias page completes without error, returns zero and changes no register.
- R4: A non-secure unprivileged access to the alias page returns a bus error.
- R5: With `sec_ext_en` low, no alias-page access is forwarded, whatever the secure flag. A privileged access reads zero and drops its write. An unprivileged access gets a bus error.
- R6: Any address outside both pages gets a bus error and touches no register. This covers the gap 0xE000F000..0xE002DFFF and every address outside the window.
- R7: The register file keeps a separate copy of each register for the secure attribute (bank 1) and the non-secure attribute (bank 0). The bank is chosen by the effective attribute only.
- R8: `rsp_valid` pulses exactly one cycle after each `req_valid`, and `rsp_err` and `rsp_rdata` arrive with it. A write response and an error response carry zero data.
- R9: Address bits [11:2] select the word in a page. Words at or above the stub depth (4) read zero, drop writes, and give no error.
- R10: After reset every register reads zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_addr | input | 32 | Byte address, word aligned |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Caller security attribute, 1 = secure |
| req_priv | input | 1 | 1 = privileged, 0 = unprivileged |
| sec_ext_en | input | 1 | Security extension present strap |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume the following about the inputs: every address is word aligned, a request is a single-cycle pulse that is answered on the next cycle, and `sec_ext_en` does not change while a request is in flight. The stimulus always builds addresses as a page base plus a word index shifted left by two. It changes the strap only between accesses and never raises `req_valid` for more than one cycle per access. The random mix covers both pages, the gap, addresses outside the window, word indices beyond the stub depth, and every combination of secure, privileged and strap.

// File: rtl/sra_pkg.sv
// Package: shared parameters and types for the alias decoder.
// Assumes 32-bit addresses and a 4 KB page.
package sra_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned PAGE_AW   = 12;
    localparam int unsigned IDX_W     = PAGE_AW - 2;
    localparam logic [31:0] MAIN_BASE = 32'hE000_E000;
    localparam logic [31:0] ALIAS_OFS = 32'h0002_0000;

    // Region an address falls into.
    typedef enum logic [1:0] {
        RG_MAIN    = 2'd0,
        RG_ALIAS   = 2'd1,
        RG_GAP     = 2'd2,
        RG_OUTSIDE = 2'd3
    } region_e;

    // Decision taken for one access.
    typedef struct packed {
        logic fwd;      // forward to register file
        logic eff_sec;  // effective security attribute
        logic err;      // bus error
    } route_t;
endpackage

// File: rtl/sra_window_decode.sv
// Window decoder: classifies an address as main page, alias page,
// gap inside the window, or outside it, and extracts the word index.
// Assumes word-aligned addresses; bits [1:0] are not looked at.
module sra_window_decode
    import sra_pkg::*;
#(
    parameter logic [31:0] BASE    = MAIN_BASE,
    parameter logic [31:0] ALIAS_D = ALIAS_OFS
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [31:0] ALIAS_BASE = BASE + ALIAS_D;
    localparam logic [31:0] WIN_END    = ALIAS_BASE + (32'd1 << PAGE_AW);
    localparam int unsigned PN_W       = ADDR_W - PAGE_AW;

    logic [PN_W-1:0] page_no;

    // Classify the address by page number and window limits.
    always_comb begin
        page_no = addr[ADDR_W-1:PAGE_AW];
        idx     = addr[PAGE_AW-1:2];
        if (page_no == BASE[ADDR_W-1:PAGE_AW])
            region = RG_MAIN;
        else if (page_no == ALIAS_BASE[ADDR_W-1:PAGE_AW])
            region = RG_ALIAS;
        else if (addr >= BASE && addr < WIN_END)
            region = RG_GAP;
        else
            region = RG_OUTSIDE;
    end
endmodule

// File: rtl/sra_attr_rewrite.sv
// Attribute rewriter: for each region decides whether the access is
// forwarded, with which effective security attribute, or whether it
// is answered locally (read-as-zero, write ignored) or with a bus error.
// Assumes the strap is stable while a request is being answered.
module sra_attr_rewrite
    import sra_pkg::*;
(
    input  region_e region,
    input  logic    secure,
    input  logic    priv,
    input  logic    sec_ext,
    output route_t  route
);
    // Per-region routing and attribute rewrite.
    always_comb begin
        route = '{fwd: 1'b0, eff_sec: 1'b0, err: 1'b0};
        unique case (region)
            RG_MAIN: begin
                route.fwd     = 1'b1;
                route.eff_sec = secure;
            end
            RG_ALIAS: begin
                if (sec_ext && secure) begin
                    route.fwd     = 1'b1;
                    route.eff_sec = 1'b0;
                end else if (!priv) begin
                    route.err = 1'b1;
                end
            end
            default: route.err = 1'b1;
        endcase
    end
endmodule

// File: rtl/sra_banked_regfile.sv
// Banked register stub: two banks (0 = non-secure, 1 = secure) of
// NREGS words. Indices at or above NREGS read zero and drop writes.
// Read is combinational; the write takes effect at the clock edge.
module sra_banked_regfile
    import sra_pkg::*;
#(
    parameter int unsigned NREGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              bank_sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned      SLOT_W = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam logic [IDX_W-1:0] LIMIT  = IDX_W'(NREGS);

    logic              hit;
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] bank_rd [2];

    // Index is valid only inside the stub depth.
    always_comb begin
        hit  = (idx < LIMIT);
        slot = idx[SLOT_W-1:0];
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DATA_W-1:0] mem [NREGS];

        // Reset or write one word of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < int'(NREGS); i++) mem[i] <= '0;
            end else if (wr_en && hit && (bank_sel == 1'(b))) begin
                mem[slot] <= wdata;
            end
        end

        // Read port of this bank.
        always_comb bank_rd[b] = hit ? mem[slot] : '0;
    end

    // Select the bank read by the effective attribute.
    always_comb rdata = bank_sel ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/sra_alias_decoder.sv
// Top: decodes the main/alias window, rewrites the security attribute,
// drives the banked stub and registers a one-cycle-later response.
// Assumes single-cycle requests and word-aligned addresses.
module sra_alias_decoder
    import sra_pkg::*;
#(
    parameter int unsigned NREGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    input  logic              req_priv,
    input  logic              sec_ext_en,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    region_e           region;
    logic [IDX_W-1:0]  idx;
    route_t            route;
    logic              rf_wr;
    logic [DATA_W-1:0] rf_rdata;
    logic              fwd_en;
    logic              fwd_sec;

    sra_window_decode u_dec (
        .addr   (req_addr),
        .region (region),
        .idx    (idx)
    );

    sra_attr_rewrite u_rw (
        .region  (region),
        .secure  (req_secure),
        .priv    (req_priv),
        .sec_ext (sec_ext_en),
        .route   (route)
    );

    // Qualify the route with the request strobe.
    always_comb begin
        fwd_en  = req_valid && route.fwd;
        fwd_sec = route.eff_sec;
        rf_wr   = fwd_en && req_write;
    end

    sra_banked_regfile #(.NREGS(NREGS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_wr),
        .bank_sel (fwd_sec),
        .idx      (idx),
        .wdata    (req_wdata),
        .rdata    (rf_rdata)
    );

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && route.err;
            rsp_rdata <= (fwd_en && !req_write) ? rf_rdata : '0;
        end
    end
endmodule

// File: rtl/sra_alias_checker.sv
// Checker for the alias decoder: port-level and route properties.
// Assumes aligned, single-cycle requests and a stable strap.
module sra_alias_checker
    import sra_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_secure,
    input logic              req_priv,
    input logic              sec_ext_en,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              fwd_en,
    input logic              fwd_sec
);
    localparam logic [31:0] ALIAS_BASE = MAIN_BASE + ALIAS_OFS;

    logic in_main, in_alias, in_gap;
    always_comb begin
        in_main  = (req_addr & 32'hFFFF_F000) == MAIN_BASE;
        in_alias = (req_addr & 32'hFFFF_F000) == ALIAS_BASE;
        in_gap   = req_addr >= (MAIN_BASE + 32'h1000) && req_addr < ALIAS_BASE;
    end

    p_main_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_main |=> !rsp_err);
    p_main_attr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_main |-> fwd_en && (fwd_sec == req_secure));
    p_alias_ns_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_alias && sec_ext_en && req_secure |-> fwd_en && !fwd_sec);
    p_alias_raz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_alias && !req_secure && req_priv |=> !rsp_err && rsp_rdata == '0);
    p_alias_user_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_alias && !req_secure && !req_priv |=> rsp_err);
    p_noext_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_alias && !sec_ext_en |-> !fwd_en);
    p_gap_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_gap |=> rsp_err);
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_err_nodata_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_rdata == '0);
endmodule

bind sra_alias_decoder sra_alias_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_secure (req_secure),
    .req_priv   (req_priv),
    .sec_ext_en (sec_ext_en),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .fwd_en     (fwd_en),
    .fwd_sec    (fwd_sec)
);

// File: tb/tb_sra_alias_decoder.sv
module tb_sra_alias_decoder;
    localparam logic [31:0] MAIN  = 32'hE000_E000;
    localparam logic [31:0] ALIAS = 32'hE002_E000;
    localparam int NREGS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_secure = 1'b0, req_priv = 1'b0, sec_ext_en = 1'b1;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] model [2][NREGS];

    always #10 clk = ~clk;

    sra_alias_decoder dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected outcome from the requirements; updates the model on writes.
    task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                          input bit sec, input bit pv, input bit ext, input string tag);
        bit fwd, eff, err;
        int idx;
        logic [31:0] exp_d;
        fwd = 0; eff = 0; err = 0; exp_d = '0;
        idx = int'(a[11:2]);
        if ((a & 32'hFFFF_F000) == MAIN) begin fwd = 1; eff = sec; end        // R1
        else if ((a & 32'hFFFF_F000) == ALIAS) begin
            if (ext && sec) begin fwd = 1; eff = 0; end                         // R2, R5
            else if (!pv) err = 1;                                              // R4
        end else err = 1;                                                       // R6
        if (fwd && idx < NREGS) begin                                           // R7, R9
            if (!wr) exp_d = model[eff][idx];
        end
        req_addr = a; req_write = wr; req_wdata = wd; req_secure = sec;
        req_priv = pv; sec_ext_en = ext; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, {tag, " R8 valid"}, {31'd0, rsp_valid}, 32'd1);
        chk(rsp_err === err, {tag, " err"}, {31'd0, rsp_err}, {31'd0, err});
        chk(rsp_rdata === exp_d, {tag, " rdata"}, rsp_rdata, exp_d);
        if (fwd && wr && idx < NREGS) model[eff][idx] = wd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int b = 0; b < 2; b++) for (int i = 0; i < NREGS; i++) model[b][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R10 idle after reset", {31'd0, rsp_valid}, 32'd0);
        // R10: all registers zero in both banks
        for (int i = 0; i < NREGS; i++) begin
            access(MAIN + 32'(i*4), 0, 0, 1, 1, 1, "R10 sec bank");
            access(MAIN + 32'(i*4), 0, 0, 0, 1, 1, "R10 ns bank");
        end
        // R7: separate banks
        access(MAIN + 4, 1, 32'hAAAA_0001, 1, 1, 1, "R7 sec write");
        access(MAIN + 4, 1, 32'h5555_0002, 0, 1, 1, "R7 ns write");
        access(MAIN + 4, 0, 0, 1, 1, 1, "R7 sec read");
        access(MAIN + 4, 0, 0, 0, 0, 1, "R1 ns user read");
        // R2: secure alias reaches non-secure bank
        access(ALIAS + 8, 1, 32'hCAFE_0003, 1, 0, 1, "R2 alias sec write");
        access(MAIN + 8, 0, 0, 0, 1, 1, "R2 ns readback");
        access(MAIN + 8, 0, 0, 1, 1, 1, "R2 sec bank untouched");
        // R3: NS priv alias is RAZ/WI
        access(ALIAS + 8, 1, 32'hDEAD_BEEF, 0, 1, 1, "R3 ns priv write");
        access(ALIAS + 8, 0, 0, 0, 1, 1, "R3 ns priv read");
        access(MAIN + 8, 0, 0, 0, 1, 1, "R3 unchanged");
        // R4
        access(ALIAS, 0, 0, 0, 0, 1, "R4 ns user read");
        // R5: strap off
        access(ALIAS + 4, 1, 32'h1234_5678, 1, 1, 0, "R5 sec priv write");
        access(MAIN + 4, 0, 0, 0, 1, 0, "R5 unchanged");
        access(ALIAS + 4, 0, 0, 1, 0, 0, "R5 sec user err");
        // R6: gap and outside
        access(MAIN + 32'h1000, 1, 32'h1111_1111, 1, 1, 1, "R6 gap low");
        access(ALIAS - 4, 0, 0, 1, 1, 1, "R6 gap high");
        access(ALIAS + 32'h1000, 0, 0, 1, 1, 1, "R6 above window");
        access(MAIN - 4, 0, 0, 1, 1, 1, "R6 below window");
        // R9: beyond stub depth
        access(MAIN + 32'h10, 1, 32'h7777_7777, 1, 1, 1, "R9 write high idx");
        access(MAIN + 32'h10, 0, 0, 1, 1, 1, "R9 read high idx");
        access(MAIN + 32'hFFC, 0, 0, 0, 1, 1, "R9 last word");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 4)      a = MAIN  + 32'($urandom_range(0, 7) * 4);
            else if (sel < 8) a = ALIAS + 32'($urandom_range(0, 7) * 4);
            else if (sel == 8) a = MAIN + 32'h1000 + 32'($urandom_range(0, 32'h7FFF) * 4);
            else              a = {$urandom()} & 32'hFFFF_FFFC;
            access(a, 1'($urandom()), $urandom(), 1'($urandom()), 1'($urandom()),
                   ($urandom_range(0, 3) != 0), "R1-mix random");
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R8 no response without request", {31'd0, rsp_valid}, 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule